// File: doc/BRIEF.md
# Staggered SDRAM Refresh Scheduler

This block decides when the memory controller must refresh its DRAM and which bank each refresh command addresses. A free-running timer in the core clock domain measures the refresh period, whose length is a programmed interval field scaled by 64. A value of zero in that field switches periodic refresh off. A rising edge on a test input forces a refresh sequence at any time.

Each refresh sequence visits the installed banks in order. It raises a request together with a bank index and holds both until the command sequencer downstream accepts them. Between one bank's accepted command and the request for the next bank, the scheduler waits a programmed number of memory-clock strobes, so that the current draw of the banks is spread out. With a zero spacing, a single broadcast request covers every bank at once. A refresh trigger that arrives while a sequence is still running is kept as one pending request, and that request starts a new sequence once the current one ends.

Top module: `refresh_sched`

## Requirements
- R1: After reset `ref_req` is low. While `interval` is zero and `test_rfsh` shows no rising edge, no request is raised.
- R2: With `interval` = N (N > 0), successive refresh sequences start N*64 core clocks apart, provided each sequence finishes within that period.
- R3: The `stagger` code selects the number of `mem_en` strobes that separate a bank's accepted command from the request for the next bank: code 0 gives 0, code 1 gives 1, code 2 gives 2 and code 3 gives 4.
- R4: With `stagger` = 0, a sequence is a single request with `ref_all` = 1 and `ref_bank` = 0, which covers every bank.
- R5: With a nonzero `stagger`, a sequence makes one request for each bank 0, 1, ... `bank_last` in increasing order, with `ref_all` = 0. `bank_last` holds the number of installed banks minus one.
- R6: Once raised, `ref_req`, `ref_bank` and `ref_all` stay unchanged until a cycle in which `ref_ack` is high. After that cycle `ref_req` is low for at least one cycle.
- R7: Each rising edge of `test_rfsh` produces exactly one refresh sequence. Holding the input high produces no further sequences.
- R8: A trigger (timer expiry or test edge) that arrives while a sequence runs is recorded and starts one further sequence after the current one ends. Several such triggers during one sequence collapse into a single pending sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous reset, active low |
| mem_en | input | 1 | One-cycle strobe per memory clock |
| interval | input | 9 | Refresh period in units of 64 core clocks; 0 turns periodic refresh off |
| stagger | input | 2 | Coded spacing between per-bank requests |
| bank_last | input | 2 | Number of installed banks minus one |
| test_rfsh | input | 1 | Test refresh; a rising edge forces one sequence |
| ref_ack | input | 1 | The downstream sequencer accepted the current request |
| ref_req | output | 1 | Refresh request |
| ref_bank | output | 2 | Bank addressed by the current request |
| ref_all | output | 1 | The current request covers all banks |

## Verification
The assertions assume that `ref_ack` is only high while `ref_req` is high. They also assume that `stagger` and `bank_last` do not change while a sequence is running, because the range and broadcast checks compare the outputs with the live inputs. The stimulus follows both rules. The acknowledge responder only answers a raised request, after a random delay. The fields are changed only after the scheduler has been idle long enough to drain every sequence. Random trials vary the spacing code, the bank count, the memory-strobe rate and the acknowledge delay. Directed cases cover broadcast refresh, a single bank, retriggering while busy, and exact period measurement.

// File: rtl/refresh_pkg.sv
// Package: shared types and the stagger-code decode for the refresh scheduler.
// Assumes: codes are two bits wide; the widest spacing is four strobes.
package refresh_pkg;

    typedef enum logic [1:0] {
        SEQ_IDLE  = 2'd0,
        SEQ_ISSUE = 2'd1,
        SEQ_GAP   = 2'd2
    } seq_state_t;

    localparam int GAP_W = 3;

    // Map a stagger code to the number of memory strobes between banks.
    function automatic logic [GAP_W-1:0] stagger_strobes(input logic [1:0] code);
        case (code)
            2'd0:    stagger_strobes = 3'd0;
            2'd1:    stagger_strobes = 3'd1;
            2'd2:    stagger_strobes = 3'd2;
            default: stagger_strobes = 3'd4;
        endcase
    endfunction

endpackage

// File: rtl/rfsh_interval_timer.sv
// Module: rfsh_interval_timer
// Counts core clocks and pulses `expire` once every interval*2^SCALE_LOG
// cycles. An interval of zero holds the counter cleared and never expires.
// Assumes: interval changes are rare; a shortened period expires at once.
module rfsh_interval_timer #(
    parameter int IW        = 9,
    parameter int SCALE_LOG = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [IW-1:0] interval,
    output logic          expire
);
    localparam int CW = IW + SCALE_LOG;

    logic [CW-1:0] count;
    logic [CW-1:0] limit;
    logic          enabled;

    // Last count value of the period (period minus one).
    always_comb begin
        enabled = (interval != '0);
        limit   = {interval, {SCALE_LOG{1'b0}}} - CW'(1);
        expire  = enabled && (count >= limit);
    end

    // Advance the period counter, wrap on expiry, clear while disabled.
    always_ff @(posedge clk) begin
        if (!rst_n || !enabled || expire) begin
            count <= '0;
        end else begin
            count <= count + CW'(1);
        end
    end

endmodule

// File: rtl/rfsh_trigger.sv
// Module: rfsh_trigger
// Merges timer expiry and the rising edge of the test input into a single
// pending flag. The flag clears when the sequencer takes it and stays set
// if a new trigger lands in the same cycle.
// Assumes: test_rfsh is synchronous to clk.
module rfsh_trigger (
    input  logic clk,
    input  logic rst_n,
    input  logic expire,
    input  logic test_rfsh,
    input  logic take,
    output logic pending
);
    logic test_q;
    logic test_edge;

    // Rising-edge detect on the test input.
    always_comb test_edge = test_rfsh && !test_q;

    // Remember the previous test input level.
    always_ff @(posedge clk) begin
        if (!rst_n) test_q <= 1'b0;
        else        test_q <= test_rfsh;
    end

    // Hold at most one outstanding refresh request.
    always_ff @(posedge clk) begin
        if (!rst_n) pending <= 1'b0;
        else        pending <= (pending && !take) || expire || test_edge;
    end

endmodule

// File: rtl/rfsh_bank_seq.sv
// Module: rfsh_bank_seq
// Runs one refresh sequence per pending trigger. It requests bank 0 first
// and steps upward to the last installed bank, waiting the coded number of
// memory strobes after each accepted command. A zero spacing turns the
// sequence into one broadcast request.
// Assumes: ack only while req is high; fields are latched at sequence start.
module rfsh_bank_seq
    import refresh_pkg::*;
#(
    parameter int NBANK = 4,
    parameter int BW    = $clog2(NBANK)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          mem_en,
    input  logic [1:0]    stagger,
    input  logic [BW-1:0] bank_last,
    input  logic          pending,
    input  logic          ack,
    output logic          take,
    output logic          req,
    output logic [BW-1:0] bank,
    output logic          all
);
    seq_state_t       state;
    logic [BW-1:0]    last_q;
    logic [1:0]       stag_q;
    logic [GAP_W-1:0] gap_cnt;

    // Request and take-pulse decode from the current state.
    always_comb begin
        req  = (state == SEQ_ISSUE);
        take = (state == SEQ_IDLE) && pending;
    end

    // Sequence state, bank pointer and inter-bank spacing counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= SEQ_IDLE;
            bank    <= '0;
            all     <= 1'b0;
            last_q  <= '0;
            stag_q  <= 2'd0;
            gap_cnt <= '0;
        end else begin
            case (state)
                SEQ_IDLE: begin
                    if (pending) begin
                        state  <= SEQ_ISSUE;
                        bank   <= '0;
                        all    <= (stagger == 2'd0);
                        last_q <= bank_last;
                        stag_q <= stagger;
                    end
                end
                SEQ_ISSUE: begin
                    if (ack) begin
                        if (all || bank == last_q) begin
                            state <= SEQ_IDLE;
                            all   <= 1'b0;
                        end else begin
                            state   <= SEQ_GAP;
                            gap_cnt <= stagger_strobes(stag_q);
                        end
                    end
                end
                SEQ_GAP: begin
                    if (mem_en) begin
                        if (gap_cnt <= GAP_W'(1)) begin
                            state <= SEQ_ISSUE;
                            bank  <= bank + BW'(1);
                        end else begin
                            gap_cnt <= gap_cnt - GAP_W'(1);
                        end
                    end
                end
                default: state <= SEQ_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/refresh_sched.sv
// Module: refresh_sched (top)
// Periodic and test-triggered DRAM refresh scheduler with per-bank
// staggering. It is built from an interval timer, a trigger/pending
// stage and a bank sequencer.
// Assumes: all inputs are synchronous to clk; mem_en is a one-cycle strobe.
module refresh_sched #(
    parameter int IW        = 9,
    parameter int SCALE_LOG = 6,
    parameter int NBANK     = 4,
    parameter int BW        = $clog2(NBANK)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          mem_en,
    input  logic [IW-1:0] interval,
    input  logic [1:0]    stagger,
    input  logic [BW-1:0] bank_last,
    input  logic          test_rfsh,
    input  logic          ref_ack,
    output logic          ref_req,
    output logic [BW-1:0] ref_bank,
    output logic          ref_all
);
    logic expire;
    logic pending;
    logic take;

    rfsh_interval_timer #(.IW(IW), .SCALE_LOG(SCALE_LOG)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .interval (interval),
        .expire   (expire)
    );

    rfsh_trigger u_trig (
        .clk       (clk),
        .rst_n     (rst_n),
        .expire    (expire),
        .test_rfsh (test_rfsh),
        .take      (take),
        .pending   (pending)
    );

    rfsh_bank_seq #(.NBANK(NBANK), .BW(BW)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .mem_en    (mem_en),
        .stagger   (stagger),
        .bank_last (bank_last),
        .pending   (pending),
        .ack       (ref_ack),
        .take      (take),
        .req       (ref_req),
        .bank      (ref_bank),
        .all       (ref_all)
    );

endmodule

// File: rtl/refresh_sched_chk.sv
// Module: refresh_sched_chk
// Protocol checks on the scheduler ports, bound onto every instance.
// Assumes: stagger and bank_last are stable while a sequence runs.
module refresh_sched_chk #(
    parameter int BW = 2
) (
    input logic          clk,
    input logic          rst_n,
    input logic [1:0]    stagger,
    input logic [BW-1:0] bank_last,
    input logic          ref_ack,
    input logic          ref_req,
    input logic [BW-1:0] ref_bank,
    input logic          ref_all
);
    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (ref_req && !ref_ack) |=> (ref_req && $stable(ref_bank) && $stable(ref_all))); // R6

    AST_DROP_AFTER_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        (ref_req && ref_ack) |=> !ref_req); // R6

    AST_BROADCAST_BANK0: assert property (@(posedge clk) disable iff (!rst_n)
        ref_all |-> (ref_req && ref_bank == '0 && stagger == 2'd0)); // R4

    AST_BANK_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        ref_req |-> (ref_bank <= bank_last)); // R5

    AST_NO_BROADCAST_STAG: assert property (@(posedge clk) disable iff (!rst_n)
        (ref_req && stagger != 2'd0) |-> !ref_all); // R5

    AST_ACK_ONLY_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        ref_ack |-> ref_req); // R6
endmodule

bind refresh_sched refresh_sched_chk #(.BW(BW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .stagger   (stagger),
    .bank_last (bank_last),
    .ref_ack   (ref_ack),
    .ref_req   (ref_req),
    .ref_bank  (ref_bank),
    .ref_all   (ref_all)
);

// File: tb/refresh_sched_test.sv
// Bench: refresh_sched_test
// Random trials with a fixed seed plus directed cases. A negedge monitor
// logs every request and checks bank order and spacing against bench-side
// expectations.
module refresh_sched_test;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 150000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       mem_en = 1'b0;
    logic [8:0] interval = '0;
    logic [1:0] stagger = 2'd1;
    logic [1:0] bank_last = 2'd3;
    logic       test_rfsh = 1'b0;
    logic       ref_ack = 1'b0;
    logic       ref_req;
    logic [1:0] ref_bank;
    logic       ref_all;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    int cmd_cnt = 0;
    int all_cnt = 0;
    int hold_viol = 0;
    int ack_delay = 0;
    int mem_per = 1;
    int mem_cnt = 0;
    int wait_cnt = 0;
    int strobes = 0;
    bit gap_on = 1'b0;
    bit prev_req = 1'b0;
    logic [1:0] prev_bank = '0;
    logic [1:0] exp_bank = '0;
    int start_t [8];
    int start_n = 0;
    bit done = 1'b0;

    refresh_sched uut (
        .clk(clk), .rst_n(rst_n), .mem_en(mem_en), .interval(interval),
        .stagger(stagger), .bank_last(bank_last), .test_rfsh(test_rfsh),
        .ref_ack(ref_ack), .ref_req(ref_req), .ref_bank(ref_bank), .ref_all(ref_all)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Expected strobe spacing for a stagger code (R3).
    function automatic int exp_gap(input logic [1:0] code);
        case (code)
            2'd0:    return 0;
            2'd1:    return 1;
            2'd2:    return 2;
            default: return 4;
        endcase
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    // Monitor, acknowledge responder and strobe generator, all at negedge.
    always @(negedge clk) begin
        cyc++;
        if (rst_n) begin
            if (ref_ack) begin
                gap_on = 1'b1;
                strobes = 0;
            end else if (gap_on) begin
                strobes += int'(mem_en);
            end
            if (ref_req && prev_req && ref_bank != prev_bank) hold_viol++;
            if (ref_req && !prev_req) begin
                cmd_cnt++;
                if (ref_all) all_cnt++;
                check(ref_bank == exp_bank, "R5 bank order", ref_bank, exp_bank);
                if (ref_bank != 2'd0)
                    check(strobes == exp_gap(stagger), "R3 stagger strobes", strobes, exp_gap(stagger));
                if (ref_bank == 2'd0 && start_n < 8) begin
                    start_t[start_n] = cyc;
                    start_n++;
                end
                exp_bank = (ref_all || ref_bank == bank_last) ? 2'd0 : ref_bank + 2'd1;
                gap_on = 1'b0;
            end
            prev_req = ref_req;
            prev_bank = ref_bank;
        end
        if (ref_ack) begin
            ref_ack = 1'b0;
        end else if (ref_req) begin
            if (wait_cnt >= ack_delay) begin
                ref_ack = 1'b1;
                wait_cnt = 0;
            end else begin
                wait_cnt++;
            end
        end
        mem_cnt++;
        mem_en = (mem_cnt % mem_per) == 0;
    end

    // Watchdog: an expired run counts as a failure and still reports.
    always @(posedge clk) begin
        if (!done && cyc > WATCHDOG) begin
            fails++;
            checks++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, WATCHDOG);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_test(input int hold);
        @(negedge clk) test_rfsh = 1'b1;
        repeat (hold) @(negedge clk);
        test_rfsh = 1'b0;
    endtask

    initial begin
        int base;
        int n;
        void'($urandom(32'd20240611));
        idle(4);
        check(ref_req == 1'b0, "R1 reset request", ref_req, 0);
        @(negedge clk) rst_n = 1'b1;
        idle(2);
        check(ref_req == 1'b0, "R1 request after reset", ref_req, 0);

        // R1: refresh off while interval is zero.
        idle(1500);
        check(cmd_cnt == 0, "R1 disabled interval", cmd_cnt, 0);

        // R7/R5/R3: random staggered test-triggered sequences.
        for (int t = 0; t < 10; t++) begin
            stagger   = 2'($urandom_range(1, 3));
            bank_last = 2'($urandom_range(0, 3));
            mem_per   = $urandom_range(1, 3);
            ack_delay = $urandom_range(0, 2);
            base = cmd_cnt;
            pulse_test($urandom_range(1, 6));
            idle(250);
            check(cmd_cnt - base == int'(bank_last) + 1, "R7 one sequence per edge", cmd_cnt - base, int'(bank_last) + 1);
        end

        // R4: broadcast at zero stagger, four banks and single bank.
        for (int t = 0; t < 2; t++) begin
            stagger   = 2'd0;
            bank_last = (t == 0) ? 2'd3 : 2'd0;
            base = all_cnt;
            n = cmd_cnt;
            pulse_test(3);
            idle(60);
            check(cmd_cnt - n == 1, "R4 single broadcast request", cmd_cnt - n, 1);
            check(all_cnt - base == 1, "R4 broadcast flag", all_cnt - base, 1);
        end

        // R8: retriggering while busy yields exactly one extra sequence.
        stagger = 2'd2; bank_last = 2'd3; mem_per = 2; ack_delay = 5;
        base = cmd_cnt;
        @(negedge clk) test_rfsh = 1'b1;
        while (cmd_cnt == base) @(negedge clk);
        idle(2); test_rfsh = 1'b0;
        idle(2); test_rfsh = 1'b1;
        idle(2); test_rfsh = 1'b0;
        idle(2); test_rfsh = 1'b1;
        idle(2); test_rfsh = 1'b0;
        idle(400);
        check(cmd_cnt - base == 8, "R8 pending collapses to one", cmd_cnt - base, 8);

        // R2: periodic refresh with measured spacing.
        for (int t = 0; t < 2; t++) begin
            stagger = 2'd0; bank_last = 2'd3; mem_per = 1;
            ack_delay = $urandom_range(0, 3);
            n = $urandom_range(1, 3);
            start_n = 0;
            interval = 9'(n);
            while (start_n < 4) @(negedge clk);
            for (int k = 1; k < 4; k++)
                check(start_t[k] - start_t[k-1] == n * 64, "R2 refresh period", start_t[k] - start_t[k-1], n * 64);
            interval = '0;
            idle(20);
            base = cmd_cnt;
            idle(800);
            check(cmd_cnt == base, "R1 refresh stops at zero", cmd_cnt - base, 0);
        end

        check(hold_viol == 0, "R6 request held until ack", hold_viol, 0);
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule